// File: doc/BRIEF.md
# Operand Address Generator

This block computes the operand location for one instruction of an 8-bit processor that has a 16-bit address space. The decoder supplies four things: the addressing mode, an optional prefix byte, and the one or two bytes that follow the opcode. The register file supplies the two index registers and the program counter. The program counter value is the one that has already been advanced past the whole instruction. One clock after a request, the block returns one of two results. It either gives a 16-bit effective address, or it raises a flag that says the operand is the byte that follows the opcode.

Six modes are supported, and each forms its result differently:

- Implied operands: no address is formed.
- Literal data: no address is formed, and the immediate flag is raised.
- Zero-page addressing: one address byte forms the low half, and the high half is zero.
- Full 16-bit addressing: two address bytes form the address.
- Register-plus-offset addressing: an unsigned byte offset is added to an index register.
- Branch displacement: a signed byte is added to the advanced program counter.

For register-plus-offset addressing, a prefix byte of 0x18 chooses the second index register (Y) in place of the first (X). All sums wrap at 16 bits.

Top module: `ea_gen`

## Requirements
- R1: A request accepted with `in_valid` high yields `out_valid` high on the following clock edge, with the result for that request. In any cycle after an edge where `in_valid` was low, `out_valid` is low.
- R2: While `rst_n` is low at a clock edge, `out_valid`, `ea` and `is_imm` all become 0.
- R3: For mode code 2 (zero page), `ea` is `{8'h00, opnd_b1}` and `is_imm` is 0.
- R4: For mode code 3 (full address), `ea` is `{opnd_b1, opnd_b2}`: the first byte is the high half. `is_imm` is 0.
- R5: For mode code 4 (indexed), `ea` is the index register plus `opnd_b1` zero-extended, modulo 2^16.
- R6: In indexed mode, the Y register is used only when `pfx_valid` is high and `pfx_byte` is 0x18. Prefix 0x1A, prefix 0xCD, any other prefix value, and no prefix all select X.
- R7: For mode code 5 (relative), `ea` is `pc_next` plus `opnd_b1` sign-extended, modulo 2^16.
- R8: For mode code 1 (immediate), `is_imm` is 1 and `ea` is 0.
- R9: For mode code 0 (inherent) and the unused codes 6 and 7, `is_imm` is 0 and `ea` is 0.
- R10: The prefix inputs have no effect on the result in any mode other than indexed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0 inherent, 1 immediate, 2 zero page, 3 full, 4 indexed, 5 relative) |
| pfx_valid | input | 1 | A prefix byte preceded the opcode |
| pfx_byte | input | 8 | Value of the prefix byte |
| opnd_b1 | input | 8 | First byte after the opcode |
| opnd_b2 | input | 8 | Second byte after the opcode |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| pc_next | input | 16 | Program counter advanced past the instruction |
| out_valid | output | 1 | Result valid |
| ea | output | 16 | Effective address |
| is_imm | output | 1 | Operand is the immediate byte; no address formed |

## Verification
The hardest cases to reach are the wrap-around sums. An indexed address crosses 0xFFFF only when the index register sits near the top and the offset is large. A backward branch passes below zero only when the program counter is near the bottom and the displacement is negative. Random draws of the 16-bit registers rarely land there, so directed cases pin X near 0xFFFF with offset 0xFF, pc_next near 0x0000 with displacement 0x80, and pc_next at 0xFFFF with displacement 0x7F. Random stimulus also mixes every prefix value into every mode, including the unused mode codes. This exercises the prefix being ignored outside indexed mode.

// File: rtl/ea_pkg.sv
// Package: shared addressing-mode codes and prefix values for the
// operand address generator. Assumes a 3-bit mode field from the decoder.
package ea_pkg;
    typedef enum logic [2:0] {
        AM_INH = 3'd0,
        AM_IMM = 3'd1,
        AM_DIR = 3'd2,
        AM_EXT = 3'd3,
        AM_IDX = 3'd4,
        AM_REL = 3'd5
    } amode_e;

    localparam logic [7:0] PFX_SEL_Y  = 8'h18;
    localparam logic [7:0] PFX_ALT_1A = 8'h1A;
    localparam logic [7:0] PFX_ALT_CD = 8'hCD;
endpackage

// File: rtl/ea_index_sel.sv
// Module: ea_index_sel
// Picks the index register used for register-plus-offset addressing.
// Only a valid prefix equal to the Y-select value chooses Y. Every other
// prefix value, and the absence of a prefix, chooses X.
// Assumes the prefix inputs are stable for the whole request cycle.
module ea_index_sel #(
    parameter int AW = 16
) (
    input  logic          pfx_valid,
    input  logic [7:0]    pfx_byte,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    output logic [AW-1:0] base,
    output logic          use_y
);
    import ea_pkg::*;

    // Decode the prefix and steer the chosen register to the adder.
    always_comb begin
        use_y = pfx_valid && (pfx_byte == PFX_SEL_Y);
        base  = use_y ? idx_y : idx_x;
    end
endmodule

// File: rtl/ea_offset_add.sv
// Module: ea_offset_add
// Adds a byte offset to an AW-bit base, wrapping modulo 2^AW.
// SIGNED_OFS picks sign extension (branch displacement) or zero
// extension (index offset) of the offset. Assumes AW > BW.
module ea_offset_add #(
    parameter int AW         = 16,
    parameter int BW         = 8,
    parameter bit SIGNED_OFS = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] ofs,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - BW;

    logic [AW-1:0] ofs_ext;

    generate
        if (SIGNED_OFS) begin : g_sext
            // Replicate the sign bit into the upper part.
            always_comb ofs_ext = {{EXT_W{ofs[BW-1]}}, ofs};
        end else begin : g_zext
            // Fill the upper part with zeros.
            always_comb ofs_ext = {{EXT_W{1'b0}}, ofs};
        end
    endgenerate

    // Form the wrapped sum; the carry out is discarded.
    always_comb sum = base + ofs_ext;
endmodule

// File: rtl/ea_gen.sv
// Module: ea_gen (top)
// Computes the operand address or the immediate flag for one request per
// cycle, with one cycle of latency. Assumes pc_next already points past
// the whole instruction and that the mode code comes from the decoder.
module ea_gen #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic          pfx_valid,
    input  logic [7:0]    pfx_byte,
    input  logic [BW-1:0] opnd_b1,
    input  logic [BW-1:0] opnd_b2,
    input  logic [AW-1:0] idx_x,
    input  logic [AW-1:0] idx_y,
    input  logic [AW-1:0] pc_next,
    output logic          out_valid,
    output logic [AW-1:0] ea,
    output logic          is_imm
);
    import ea_pkg::*;

    localparam int HI_W = AW - BW;

    logic [AW-1:0] idx_base;
    logic          idx_use_y;
    logic [AW-1:0] idx_sum;
    logic [AW-1:0] rel_sum;
    logic [AW-1:0] ea_d;
    logic          imm_d;

    ea_index_sel #(.AW(AW)) u_sel (
        .pfx_valid (pfx_valid),
        .pfx_byte  (pfx_byte),
        .idx_x     (idx_x),
        .idx_y     (idx_y),
        .base      (idx_base),
        .use_y     (idx_use_y)
    );

    ea_offset_add #(.AW(AW), .BW(BW), .SIGNED_OFS(1'b0)) u_idx_add (
        .base (idx_base),
        .ofs  (opnd_b1),
        .sum  (idx_sum)
    );

    ea_offset_add #(.AW(AW), .BW(BW), .SIGNED_OFS(1'b1)) u_rel_add (
        .base (pc_next),
        .ofs  (opnd_b1),
        .sum  (rel_sum)
    );

    // Select the result for the current mode; unused codes form no address.
    always_comb begin
        ea_d  = '0;
        imm_d = 1'b0;
        case (mode)
            AM_IMM: imm_d = 1'b1;
            AM_DIR: ea_d  = {{HI_W{1'b0}}, opnd_b1};
            AM_EXT: ea_d  = {opnd_b1, opnd_b2};
            AM_IDX: ea_d  = idx_sum;
            AM_REL: ea_d  = rel_sum;
            default: begin
                ea_d  = '0;
                imm_d = 1'b0;
            end
        endcase
    end

    // Register the result; synchronous active-low reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ea        <= '0;
            is_imm    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ea        <= ea_d;
            is_imm    <= imm_d;
        end
    end

    // R1: a result appears exactly one cycle after each request.
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: the zero-page high half is clear.
    assert_dir_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_DIR) |=> (ea[AW-1:BW] == '0 && !is_imm));

    // R4: full addressing places the first byte in the high half.
    assert_ext_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_EXT) |=> (ea == {$past(opnd_b1), $past(opnd_b2)}));

    // R8: immediate mode raises the flag and forms no address.
    assert_imm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == AM_IMM) |=> (is_imm && ea == '0));

    // R9: inherent and unused codes give neither an address nor the flag.
    assert_inh_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == AM_INH || mode > AM_REL)) |=> (!is_imm && ea == '0));

    // R6: only the Y-select prefix may route Y into the index adder.
    assert_y_only_on_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_use_y |-> (pfx_valid && pfx_byte == PFX_SEL_Y));
endmodule

// File: tb/ea_gen_tb.sv
// Bench for ea_gen: directed corner cases, then seeded random requests.
// Each result is compared with a reference computed from the requirements.
module ea_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        pfx_valid = 1'b0;
    logic [7:0]  pfx_byte = '0;
    logic [7:0]  opnd_b1 = '0;
    logic [7:0]  opnd_b2 = '0;
    logic [15:0] idx_x = '0;
    logic [15:0] idx_y = '0;
    logic [15:0] pc_next = '0;
    logic        out_valid;
    logic [15:0] ea;
    logic        is_imm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .pfx_valid(pfx_valid), .pfx_byte(pfx_byte),
        .opnd_b1(opnd_b1), .opnd_b2(opnd_b2),
        .idx_x(idx_x), .idx_y(idx_y), .pc_next(pc_next),
        .out_valid(out_valid), .ea(ea), .is_imm(is_imm)
    );

    // Reference address from the requirements.
    function automatic logic [15:0] ref_ea(input logic [2:0] m, input logic pv,
            input logic [7:0] pb, input logic [7:0] b1, input logic [7:0] b2,
            input logic [15:0] x, input logic [15:0] y, input logic [15:0] pc);
        logic [15:0] r;
        case (m)
            3'd2: r = {8'h00, b1};
            3'd3: r = {b1, b2};
            3'd4: r = ((pv && pb == 8'h18) ? y : x) + {8'h00, b1};
            3'd5: r = pc + {{8{b1[7]}}, b1};
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one request at the falling edge and check after the next rising edge.
    task automatic run(input string req, input logic [2:0] m, input logic pv,
            input logic [7:0] pb, input logic [7:0] b1, input logic [7:0] b2,
            input logic [15:0] x, input logic [15:0] y, input logic [15:0] pc);
        @(negedge clk);
        in_valid = 1'b1; mode = m; pfx_valid = pv; pfx_byte = pb;
        opnd_b1 = b1; opnd_b2 = b2; idx_x = x; idx_y = y; pc_next = pc;
        @(posedge clk);
        #1;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " ea"}, {16'd0, ea}, {16'd0, ref_ea(m, pv, pb, b1, b2, x, y, pc)});
        check({req, " imm"}, {31'd0, is_imm}, {31'd0, (m == 3'd1)});
    endtask

    initial begin
        int unsigned seed_r;
        seed_r = $urandom(32'd24681);
        // R2: reset state.
        repeat (3) @(posedge clk);
        #1;
        check("R2 valid", {31'd0, out_valid}, 32'd0);
        check("R2 ea", {16'd0, ea}, 32'd0);
        check("R2 imm", {31'd0, is_imm}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        run("R3 zero page", 3'd2, 1'b0, 8'h00, 8'hFF, 8'h12, 16'h1111, 16'h2222, 16'h3333);
        run("R10 zero page prefix", 3'd2, 1'b1, 8'h18, 8'h5A, 8'h77, 16'h1111, 16'h2222, 16'h3333);
        run("R4 full", 3'd3, 1'b0, 8'h00, 8'hB6, 8'h01, 16'h0, 16'h0, 16'h0);
        run("R5 index wrap", 3'd4, 1'b0, 8'h00, 8'hFF, 8'h00, 16'hFFFF, 16'h0100, 16'h0);
        run("R5 index zero ext", 3'd4, 1'b0, 8'h00, 8'h80, 8'h00, 16'h1000, 16'h0, 16'h0);
        run("R6 prefix 18 Y", 3'd4, 1'b1, 8'h18, 8'h10, 8'h00, 16'h1000, 16'hC000, 16'h0);
        run("R6 prefix 1A X", 3'd4, 1'b1, 8'h1A, 8'h10, 8'h00, 16'h1000, 16'hC000, 16'h0);
        run("R6 prefix CD X", 3'd4, 1'b1, 8'hCD, 8'h10, 8'h00, 16'h1000, 16'hC000, 16'h0);
        run("R6 18 without valid X", 3'd4, 1'b0, 8'h18, 8'h10, 8'h00, 16'h1000, 16'hC000, 16'h0);
        run("R7 back wrap", 3'd5, 1'b0, 8'h00, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0001);
        run("R7 fwd wrap", 3'd5, 1'b0, 8'h00, 8'h7F, 8'h00, 16'h0, 16'h0, 16'hFFFF);
        run("R8 immediate", 3'd1, 1'b1, 8'h18, 8'hAA, 8'hBB, 16'h1, 16'h2, 16'h3);
        run("R9 inherent", 3'd0, 1'b0, 8'h00, 8'hAA, 8'hBB, 16'h1, 16'h2, 16'h3);
        run("R9 code 7", 3'd7, 1'b1, 8'h18, 8'hAA, 8'hBB, 16'h1, 16'h2, 16'h3);

        // R1: no request gives no valid.
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 idle", {31'd0, out_valid}, 32'd0);

        // Random mix over all modes and prefixes (R1 R3 R4 R5 R6 R7 R8 R9 R10).
        for (int i = 0; i < 400; i++) begin
            logic [7:0] pb;
            int unsigned sel;
            sel = $urandom % 5;
            pb = (sel == 0) ? 8'h18 : (sel == 1) ? 8'h1A : (sel == 2) ? 8'hCD : 8'($urandom);
            run("R1 random", 3'($urandom), 1'($urandom), pb, 8'($urandom), 8'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom));
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule